// File: doc/BRIEF.md
# Burst ROM Page-Read Controller

This block reads external ROM that supports page (nibble) mode. A requester presents a base address with a bus width, a burst code and a first-beat wait count, then raises `req`. The controller drives the ROM address and asserts chip select and read strobe. It then performs a run of consecutive reads. Between beats it moves only the address and never releases the select.

Each beat is one address cycle followed by its wait cycles. The first beat takes the programmed wait count. Every later beat takes exactly two wait cycles. A `rom_wait` input can stretch the last wait cycle of a beat. The requester can suppress it with `ign_wait`, which is captured together with the request.

A beat's data is registered at the end of its last cycle and shown for one cycle with `data_vld`. After the final beat the controller spends one cycle in a completion state. In that cycle it releases the ROM strobes and pulses `ack`.

The controller has four states:
- IDLE: waiting for a request. The transition *accept* leads to ADDR.
- ADDR: the address cycle of a beat. The transition *to_wait* leads to WAITC. When the beat has no wait cycles, the transition *next_beat* leads to ADDR and *finish* leads to DONE.
- WAITC: the wait cycles of a beat. The transition *stall* stays in WAITC. After the last wait cycle, *next_beat* leads to ADDR and *finish* leads to DONE.
- DONE: the completion cycle. The transition *release* leads back to IDLE.

Top module: `burst_rom_ctrl`

## Requirements
- R1: When `req` is high in IDLE, the block latches the configuration and base address. In the next cycle it presents the first beat address with `rom_cs_n` and `rom_rd_n` both low.
- R2: `cfg_burst` selects the beat count. Code 0 gives one beat (a single read), code 1 gives 4, code 2 gives 8 and code 3 gives 16. `cfg_width` selects the ROM width: 0 is 8 bits, 1 is 16 bits, and 2 or 3 is 32 bits.
- R3: A burst code that is illegal for the width is clamped to the largest legal count. That count is 16 for 8-bit ROM, 8 for 16-bit ROM and 4 for 32-bit ROM.
- R4: `rom_cs_n` and `rom_rd_n` stay low from the first address cycle until the final beat completes.
- R5: The first address is `base_addr` aligned down to the burst size in bytes (beat count times byte width). Each later beat adds the byte width (1, 2 or 4). The address changes only at beat boundaries.
- R6: The first beat has `cfg_wait` wait cycles. Every later beat has exactly two wait cycles, including when `cfg_wait` is 0.
- R7: `rom_wait` is sampled in the last wait cycle of a beat. On the first beat this happens only when `cfg_wait` is at least 1. On later beats it always happens. Each high sample extends the beat by one cycle.
- R8: When `ign_wait` was high at acceptance, `rom_wait` has no effect on the timing of any beat of that burst.
- R9: `rom_data` is captured at the end of a beat's last cycle. In the following cycle `data_out` shows it and `data_vld` is high for exactly that one cycle.
- R10: After the final beat there is one cycle with `ack` high and both strobes high. The block then returns to IDLE.
- R11: During reset and after it, `rom_cs_n` and `rom_rd_n` are high and `ack` and `data_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Read request, accepted in IDLE |
| base_addr | input | ADDR_W | Byte address of the request |
| cfg_width | input | 2 | ROM width code |
| cfg_burst | input | 2 | Burst length code |
| cfg_wait | input | WAIT_W | Wait cycles for the first beat |
| ign_wait | input | 1 | Ignore `rom_wait` for this request |
| ack | output | 1 | One-cycle completion pulse |
| rom_addr | output | ADDR_W | ROM byte address |
| rom_cs_n | output | 1 | ROM chip select, active low |
| rom_rd_n | output | 1 | ROM read strobe, active low |
| rom_data | input | DATA_W | ROM read data |
| rom_wait | input | 1 | ROM wait request, active high |
| data_out | output | DATA_W | Captured beat data |
| data_vld | output | 1 | Beat data valid pulse |

## Verification
The bound checker watches these properties on every cycle:
- the select stays held until `ack`;
- the address moves only at beat boundaries and by the width step;
- `ack` is a single pulse with both strobes high;
- later beats are spaced at least three cycles apart.

Other behaviours are shown only by the bench. It sweeps widths, burst codes, wait counts, the ignore flag and WAIT stretch lengths. For each case it compares capture cycles, addresses, data and the `ack` cycle with an arithmetic model. Alignment of the first address, clamping, exact wait counts and the first-beat sampling rule appear only there.

// File: rtl/brc_pkg.sv
package brc_pkg;
    localparam int MAX_BEATS   = 16;
    localparam int BEAT_W      = $clog2(MAX_BEATS + 1);
    localparam int LATER_WAITS = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_WAITC = 2'd2,
        ST_DONE  = 2'd3
    } brc_state_e;
endpackage

// File: rtl/brc_cfg_decode.sv
module brc_cfg_decode
    import brc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [1:0]        width_code,
    input  logic [1:0]        burst_code,
    input  logic [ADDR_W-1:0] base,
    output logic [1:0]        shift,
    output logic [BEAT_W-1:0] beats,
    output logic [ADDR_W-1:0] start
);
    logic [1:0]        max_code;
    logic [1:0]        code;
    logic [ADDR_W-1:0] bytes;

    always_comb begin
        unique case (width_code)
            2'd0:    shift = 2'd0;
            2'd1:    shift = 2'd1;
            default: shift = 2'd2;
        endcase
        unique case (shift)
            2'd0:    max_code = 2'd3;
            2'd1:    max_code = 2'd2;
            default: max_code = 2'd1;
        endcase
        code  = (burst_code > max_code) ? max_code : burst_code;
        beats = (code == 2'd0) ? BEAT_W'(1) : (BEAT_W'(2) << code);
        bytes = ADDR_W'(beats) << shift;
        start = base & ~(bytes - ADDR_W'(1));
    end
endmodule

// File: rtl/brc_addr_gen.sv
module brc_addr_gen #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] start,
    input  logic              adv,
    input  logic [1:0]        shift,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= start;
        end else if (adv) begin
            addr <= addr + (ADDR_W'(1) << shift);
        end
    end
endmodule

// File: rtl/brc_down_ctr.sv
module brc_down_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    input  logic         dec,
    output logic         one
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign one = (cnt == W'(1));
endmodule

// File: rtl/burst_rom_ctrl.sv
module burst_rom_ctrl
    import brc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [1:0]        cfg_width,
    input  logic [1:0]        cfg_burst,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              ign_wait,
    output logic              ack,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_cs_n,
    output logic              rom_rd_n,
    input  logic [DATA_W-1:0] rom_data,
    input  logic              rom_wait,
    output logic [DATA_W-1:0] data_out,
    output logic              data_vld
);
    localparam int CNT_W = (WAIT_W > 2) ? WAIT_W : 2;

    brc_state_e        state, state_nx;
    logic [1:0]        shift_d, width_q;
    logic [BEAT_W-1:0] beats_d;
    logic [ADDR_W-1:0] start_d;
    logic [WAIT_W-1:0] wait0_q;
    logic              ign_q;
    logic              first_q;
    logic              accept;
    logic              capture;
    logic              wload;
    logic              wdec;
    logic              wone;
    logic              bone;
    logic [CNT_W-1:0]  nwait;
    logic              sample_en;

    brc_cfg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .width_code (cfg_width),
        .burst_code (cfg_burst),
        .base       (base_addr),
        .shift      (shift_d),
        .beats      (beats_d),
        .start      (start_d)
    );

    brc_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .start (start_d),
        .adv   (capture),
        .shift (width_q),
        .addr  (rom_addr)
    );

    brc_down_ctr #(.W(BEAT_W)) u_beats (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .val   (beats_d),
        .dec   (capture),
        .one   (bone)
    );

    brc_down_ctr #(.W(CNT_W)) u_waits (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wload),
        .val   (nwait),
        .dec   (wdec),
        .one   (wone)
    );

    // per-request configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q <= 2'd0;
            wait0_q <= '0;
            ign_q   <= 1'b0;
            first_q <= 1'b0;
        end else if (accept) begin
            width_q <= shift_d;
            wait0_q <= cfg_wait;
            ign_q   <= ign_wait;
            first_q <= 1'b1;
        end else if (capture) begin
            first_q <= 1'b0;
        end
    end

    always_comb begin
        nwait     = first_q ? CNT_W'(wait0_q) : CNT_W'(LATER_WAITS);
        sample_en = !ign_q && (first_q ? (wait0_q != '0) : 1'b1);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state and control strobes
    always_comb begin
        state_nx = state;
        accept   = 1'b0;
        capture  = 1'b0;
        wload    = 1'b0;
        wdec     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    accept   = 1'b1;
                    state_nx = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (nwait == '0) begin
                    capture  = 1'b1;
                    state_nx = bone ? ST_DONE : ST_ADDR;
                end else begin
                    wload    = 1'b1;
                    state_nx = ST_WAITC;
                end
            end
            ST_WAITC: begin
                if (!wone) begin
                    wdec = 1'b1;
                end else if (!(sample_en && rom_wait)) begin
                    capture  = 1'b1;
                    state_nx = bone ? ST_DONE : ST_ADDR;
                end
            end
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rom_cs_n = 1'b1;
        rom_rd_n = 1'b1;
        ack      = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_ADDR, ST_WAITC: begin
                rom_cs_n = 1'b0;
                rom_rd_n = 1'b0;
            end
            ST_DONE:  ack = 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_vld <= 1'b0;
            data_out <= '0;
        end else begin
            data_vld <= capture;
            if (capture) data_out <= rom_data;
        end
    end
endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rom_cs_n,
    input logic              rom_rd_n,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              ack,
    input logic              data_vld,
    input logic [1:0]        width_q
);
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R10
    AST_ACK_STROBES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (rom_cs_n && rom_rd_n)); // R10
    AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_cs_n |=> (!rom_cs_n || ack)); // R4
    AST_ADDR_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_cs_n && !$past(rom_cs_n) && !$stable(rom_addr)) |-> data_vld); // R5
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_vld && !rom_cs_n && !$past(rom_cs_n)) |->
            (rom_addr == $past(rom_addr) + (ADDR_W'(1) << width_q))); // R5
    AST_LATER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_vld && !rom_cs_n) |=> !data_vld ##1 !data_vld); // R6
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |-> (rom_cs_n && rom_rd_n && !ack && !data_vld)); // R11
endmodule

bind burst_rom_ctrl brc_checker #(.ADDR_W(ADDR_W)) u_brc_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rom_cs_n (rom_cs_n),
    .rom_rd_n (rom_rd_n),
    .rom_addr (rom_addr),
    .ack      (ack),
    .data_vld (data_vld),
    .width_q  (width_q)
);

// File: tb/tb_burst_rom_ctrl.sv
module tb_burst_rom_ctrl;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int WAIT_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [1:0]        cfg_width = '0;
    logic [1:0]        cfg_burst = '0;
    logic [WAIT_W-1:0] cfg_wait = '0;
    logic              ign_wait = 1'b0;
    logic              ack;
    logic [ADDR_W-1:0] rom_addr;
    logic              rom_cs_n;
    logic              rom_rd_n;
    logic [DATA_W-1:0] rom_data;
    logic              rom_wait = 1'b0;
    logic [DATA_W-1:0] data_out;
    logic              data_vld;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    assign rom_data = {rom_addr ^ 16'hA5C3, rom_addr};

    burst_rom_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .base_addr(base_addr),
        .cfg_width(cfg_width), .cfg_burst(cfg_burst), .cfg_wait(cfg_wait),
        .ign_wait(ign_wait), .ack(ack), .rom_addr(rom_addr),
        .rom_cs_n(rom_cs_n), .rom_rd_n(rom_rd_n), .rom_data(rom_data),
        .rom_wait(rom_wait), .data_out(data_out), .data_vld(data_vld)
    );

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic run_one(input int w, input int b, input int wt, input int ig,
                           input int s, input int base);
        int shift, maxc, code, beats, bytes, start, t, n, tend;
        int cap[16];
        bit cs_ok, vld_ok, ack_ok;
        shift = (w == 0) ? 0 : (w == 1) ? 1 : 2;                 // R2
        maxc  = (shift == 0) ? 3 : (shift == 1) ? 2 : 1;         // R3
        code  = (b > maxc) ? maxc : b;
        beats = (code == 0) ? 1 : (2 << code);
        bytes = beats << shift;
        start = base & ~(bytes - 1) & 16'hFFFF;                  // R5
        t = 0;
        for (int k = 0; k < beats; k++) begin
            t += 1;
            n = (k == 0) ? wt : 2;                               // R6
            if (n > 0) begin
                t += n - 1;
                if (ig == 0) while (t < s) t++;                  // R7 R8
                t += 1;
            end
            cap[k] = t;
        end
        tend = t;
        @(negedge clk);
        req = 1'b1; base_addr = ADDR_W'(base); cfg_width = 2'(w);
        cfg_burst = 2'(b); cfg_wait = WAIT_W'(wt); ign_wait = ig[0];
        rom_wait = 1'b0;
        @(negedge clk);
        req = 1'b0;
        cs_ok = 1; vld_ok = 1; ack_ok = 1;
        for (int idx = 0; idx <= tend; idx++) begin
            bit ev;
            rom_wait = (idx < s);
            if (idx == 0)
                chk(!rom_cs_n && !rom_rd_n && rom_addr == ADDR_W'(start),
                    "R1", {rom_cs_n, rom_rd_n, rom_addr}, start);
            if (idx < tend && (rom_cs_n || rom_rd_n)) cs_ok = 0;
            ev = 0;
            for (int k = 0; k < beats; k++) begin
                if (idx == cap[k] - 1)
                    chk(rom_addr == ADDR_W'(start + (k << shift)), "R5",
                        rom_addr, start + (k << shift));
                if (idx == cap[k]) begin
                    ev = 1;
                    chk(data_vld && data_out ==
                        {ADDR_W'(start + (k << shift)) ^ 16'hA5C3,
                         ADDR_W'(start + (k << shift))},
                        "R9", data_out, start + (k << shift));
                end
            end
            if (data_vld != ev) vld_ok = 0;
            if (ack != (idx == tend)) ack_ok = 0;
            if (idx == tend && (!rom_cs_n || !rom_rd_n)) ack_ok = 0;
            @(negedge clk);
        end
        chk(cs_ok, "R4", 0, 1);
        chk(vld_ok, ig ? "R8" : "R7", 0, 1);
        chk(ack_ok, "R10", 0, 1);
        chk(!ack && rom_cs_n && !data_vld, "R10", {ack, rom_cs_n, data_vld}, 2);
        rom_wait = 1'b0;
    endtask

    initial begin
        int seed;
        repeat (3) @(negedge clk);
        chk(rom_cs_n && rom_rd_n && !ack && !data_vld, "R11",
            {rom_cs_n, rom_rd_n, ack, data_vld}, 4'b1100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rom_cs_n && rom_rd_n && !ack && !data_vld, "R11",
            {rom_cs_n, rom_rd_n, ack, data_vld}, 4'b1100);
        seed = 16'h1234;
        for (int w = 0; w < 4; w++)
            for (int b = 0; b < 4; b++)
                for (int wt = 0; wt < 4; wt++)
                    for (int ig = 0; ig < 2; ig++)
                        for (int si = 0; si < 3; si++) begin
                            seed = (seed * 37 + 101) & 16'hFFFF;
                            run_one(w, b, wt, ig, (si == 0) ? 0 : (si == 1) ? 2 : 6, seed);
                        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                chk(0, "watchdog", 0, 1);
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule